// File: doc/BRIEF.md
# Nibble-Serial Trace Port Transmitter

This block drains 64-bit trace words from a show-ahead FIFO and sends them out through a 4-bit data port with a free-running trace clock. Each word goes out as sixteen nibbles, least significant nibble first. Both edges of the trace clock mark a new nibble. The port carries no framing strobe. A receiver spots the start of a word because a valid word's lowest nibble is never zero, and it then counts fifteen more nibbles. Between words the data port sits at zero and the clock keeps toggling.

Two port speeds are available. In the fast setting one nibble leaves per core cycle, so the trace clock runs at half the core clock. In the slow setting one nibble leaves every two core cycles, so the trace clock runs at a quarter of the core clock. The port is live only while off-chip mode is enabled and the probe-detect input reports a probe. On the write side of the FIFO, a guard either asks the core to stall or reports a dropped word, depending on the inhibit-overflow setting. The stall request goes up while enough free entries remain to absorb the pipeline's stall latency.

Three states drive the transmitter. TX_OFF holds the port quiet while it is disabled. TX_IDLE drives zero and waits for a slot with a word available. TX_SEND shifts one nibble per slot. The transitions are as follows:
- OFF→IDLE when the port becomes live.
- IDLE→SEND on a slot with the FIFO non-empty.
- SEND→SEND when the last nibble ends and another word is waiting.
- SEND→IDLE when the last nibble ends and the FIFO is empty.
- Any state→OFF when the port is disabled.

Top module: `nibble_trace_tx`

## Requirements
- R1: A word popped from the FIFO appears on `tr_data` as 16 nibbles in one-nibble slots, bits [3:0] first and bits [63:60] last. A new nibble is presented each time `tr_clk` changes level.
- R2: While no word is being sent, `tr_data` is 0 and `tr_clk` keeps toggling.
- R3: With `cfg_fast`=1 (and the port live), `tr_clk` toggles every core cycle and one nibble is sent per core cycle.
- R4: With `cfg_fast`=0 (and the port live), `tr_clk` toggles every second core cycle and each nibble is held for two core cycles.
- R5: When `cfg_offchip`=0 or `probe_absent`=1, the port is disabled. In that case `tr_data` is 0, `tr_clk` is held low and the FIFO is never popped.
- R6: `fifo_pop` is raised only when the FIFO is non-empty, and only in the slot that starts a word: from idle, or at the end of the 16th nibble of the previous word.
- R7: Queued words go out back to back. The first nibble of the next word occupies the slot right after the 16th nibble of the current word.
- R8: `core_stall` is 1 exactly when `cfg_offchip`=1, `cfg_inhibit_ovf`=1 and `fifo_free` ≤ STALL_LAT. The inhibit setting has no effect when `cfg_offchip`=0.
- R9: `ovf_pulse` is 1 exactly when `push_req`=1, `fifo_free`=0, `cfg_offchip`=1 and `cfg_inhibit_ovf`=0. A dropped word is never accepted.
- R10: `push_ok` is 1 exactly when `push_req`=1 and `fifo_free` is non-zero.
- R11: During reset, `tr_data`=0, `tr_clk`=0 and `fifo_pop`=0, even with a word waiting in the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_offchip | input | 1 | Off-chip mode enable; gates the port and both other settings |
| cfg_fast | input | 1 | 1: nibble per core cycle; 0: nibble per two core cycles |
| cfg_inhibit_ovf | input | 1 | 1: stall the core when the FIFO is nearly full; 0: drop words |
| probe_absent | input | 1 | High when no probe is attached; disables the port |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_word | input | WORD_W | Head word of the show-ahead FIFO |
| fifo_pop | output | 1 | Removes the head word this cycle |
| push_req | input | 1 | Core has a packed trace word to write |
| fifo_free | input | FREE_W | Free FIFO entries |
| push_ok | output | 1 | Word is written into the FIFO |
| core_stall | output | 1 | Stall request to the core pipeline |
| ovf_pulse | output | 1 | Word lost; an overflow marker must follow |
| tr_clk | output | 1 | Trace clock, both edges significant |
| tr_data | output | NIB_W | Trace data nibble |

## Verification
The bench uses the default parameters: 64-bit words, 4-bit nibbles, a 5-bit free count and a stall latency of 3. With these values a full word takes 16 slots. Bursts of queued words therefore show where the 16th nibble ends and the next word begins, in both fast and slow settings. A latency of 3 places the stall threshold at a small free count, so the checks can land on both sides of it, and a zero free count reaches the drop path.

// File: rtl/tpx_pkg.sv
package tpx_pkg;
    typedef enum logic [1:0] {
        TX_OFF  = 2'd0,
        TX_IDLE = 2'd1,
        TX_SEND = 2'd2
    } tx_state_e;
endpackage

// File: rtl/tpx_clock_gen.sv
module tpx_clock_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic port_en,
    input  logic fast_eff,
    output logic step,
    output logic tr_clk
);
    logic phase_q;
    logic clk_q;

    assign step   = port_en & (fast_eff | phase_q);
    assign tr_clk = clk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
            clk_q   <= 1'b0;
        end else if (!port_en) begin
            phase_q <= 1'b0;
            clk_q   <= 1'b0;
        end else begin
            phase_q <= ~phase_q;
            if (step) begin
                clk_q <= ~clk_q;
            end
        end
    end

    // R3: fast ratio toggles the trace clock on every core cycle
    assert_fast_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(port_en && fast_eff)) |-> (tr_clk != $past(tr_clk)));

    // R4: slow ratio holds the trace clock for one cycle after each toggle
    assert_slow_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(port_en && !fast_eff) && port_en && !fast_eff
         && (tr_clk != $past(tr_clk))) |=> (tr_clk == $past(tr_clk)));
endmodule

// File: rtl/tpx_shifter.sv
module tpx_shifter
    import tpx_pkg::*;
#(
    parameter int WORD_W = 64,
    parameter int NIB_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_en,
    input  logic              step,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_word,
    output logic              fifo_pop,
    output logic [NIB_W-1:0]  tr_data
);
    localparam int NIBBLES = WORD_W / NIB_W;
    localparam int CNT_W   = $clog2(NIBBLES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NIBBLES - 1);

    tx_state_e         state_q, state_d;
    logic [WORD_W-1:0] shreg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              load, shift;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and strobes
    always_comb begin
        state_d  = state_q;
        fifo_pop = 1'b0;
        load     = 1'b0;
        shift    = 1'b0;
        unique case (state_q)
            TX_OFF: begin
                if (port_en) state_d = TX_IDLE;
            end
            TX_IDLE: begin
                if (!port_en) begin
                    state_d = TX_OFF;
                end else if (step && !fifo_empty) begin
                    fifo_pop = 1'b1;
                    load     = 1'b1;
                    state_d  = TX_SEND;
                end
            end
            TX_SEND: begin
                if (!port_en) begin
                    state_d = TX_OFF;
                end else if (step) begin
                    if (cnt_q == LAST) begin
                        if (!fifo_empty) begin
                            fifo_pop = 1'b1;
                            load     = 1'b1;
                        end else begin
                            state_d = TX_IDLE;
                        end
                    end else begin
                        shift = 1'b1;
                    end
                end
            end
            default: state_d = TX_OFF;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            cnt_q   <= '0;
        end else if (load) begin
            shreg_q <= fifo_word;
            cnt_q   <= '0;
        end else if (shift) begin
            shreg_q <= {{NIB_W{1'b0}}, shreg_q[WORD_W-1:NIB_W]};
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        tr_data = '0;
        if (state_q == TX_SEND) begin
            tr_data = shreg_q[NIB_W-1:0];
        end
    end

    // R6: never pop an empty FIFO
    assert_pop_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty);

    // R6: pops land only at a word boundary
    assert_pop_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> (state_q == TX_IDLE || cnt_q == LAST));

    // R1: each slot inside a word advances exactly one nibble
    assert_nibble_advance_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(state_q == TX_SEND && port_en && step && cnt_q != LAST))
        |-> (state_q == TX_SEND && cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

    // R7: a pop at the last nibble keeps the transmitter sending
    assert_back_to_back_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_SEND && fifo_pop) |=> (state_q == TX_SEND && cnt_q == '0));
endmodule

// File: rtl/tpx_fill_guard.sv
module tpx_fill_guard #(
    parameter int FREE_W    = 5,
    parameter int STALL_LAT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_offchip,
    input  logic              cfg_inhibit_ovf,
    input  logic              push_req,
    input  logic [FREE_W-1:0] fifo_free,
    output logic              push_ok,
    output logic              core_stall,
    output logic              ovf_pulse
);
    localparam logic [FREE_W-1:0] THRESH = FREE_W'(STALL_LAT);

    logic inhibit_eff;
    logic drop_eff;
    logic full;

    always_comb begin
        inhibit_eff = cfg_offchip & cfg_inhibit_ovf;
        drop_eff    = cfg_offchip & ~cfg_inhibit_ovf;
        full        = (fifo_free == '0);
        push_ok     = push_req & ~full;
        core_stall  = inhibit_eff & (fifo_free <= THRESH);
        ovf_pulse   = drop_eff & push_req & full;
    end

    // R9: a dropped word is never written
    assert_drop_not_written_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> (!push_ok && !core_stall));

    // R8: stall only in off-chip mode with the inhibit setting
    assert_stall_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        core_stall |-> (cfg_offchip && cfg_inhibit_ovf));

    // R10: a write is only accepted with free space
    assert_push_space_R10: assert property (@(posedge clk) disable iff (!rst_n)
        push_ok |-> (push_req && fifo_free != '0));
endmodule

// File: rtl/nibble_trace_tx.sv
module nibble_trace_tx #(
    parameter int WORD_W    = 64,
    parameter int NIB_W     = 4,
    parameter int FREE_W    = 5,
    parameter int STALL_LAT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_offchip,
    input  logic              cfg_fast,
    input  logic              cfg_inhibit_ovf,
    input  logic              probe_absent,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_word,
    output logic              fifo_pop,
    input  logic              push_req,
    input  logic [FREE_W-1:0] fifo_free,
    output logic              push_ok,
    output logic              core_stall,
    output logic              ovf_pulse,
    output logic              tr_clk,
    output logic [NIB_W-1:0]  tr_data
);
    logic port_en;
    logic fast_eff;
    logic step;

    assign port_en  = cfg_offchip & ~probe_absent;
    assign fast_eff = cfg_offchip & cfg_fast;

    tpx_clock_gen u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .port_en  (port_en),
        .fast_eff (fast_eff),
        .step     (step),
        .tr_clk   (tr_clk)
    );

    tpx_shifter #(
        .WORD_W (WORD_W),
        .NIB_W  (NIB_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .port_en    (port_en),
        .step       (step),
        .fifo_empty (fifo_empty),
        .fifo_word  (fifo_word),
        .fifo_pop   (fifo_pop),
        .tr_data    (tr_data)
    );

    tpx_fill_guard #(
        .FREE_W    (FREE_W),
        .STALL_LAT (STALL_LAT)
    ) u_guard (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_offchip     (cfg_offchip),
        .cfg_inhibit_ovf (cfg_inhibit_ovf),
        .push_req        (push_req),
        .fifo_free       (fifo_free),
        .push_ok         (push_ok),
        .core_stall      (core_stall),
        .ovf_pulse       (ovf_pulse)
    );

    // R5: a disabled port goes quiet on the next cycle
    assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(port_en)) |-> (tr_data == '0 && !tr_clk));

    // R5: a disabled port never pops
    assert_disabled_no_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |-> !fifo_pop);

    // R11: quiet outputs while reset is held
    always_comb begin
        if (!rst_n) begin
            assert_reset_quiet_R11: assert (tr_data == '0 && !tr_clk && !fifo_pop);
        end
    end
endmodule

// File: tb/tb_nibble_trace_tx.sv
module tb_nibble_trace_tx;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    // {fast, word}
    localparam logic [64:0] VEC [NVEC] = '{
        {1'b1, 64'h0123_4567_89AB_CDEF},
        {1'b1, 64'hFEDC_BA98_7654_3211},
        {1'b0, 64'h0000_0000_0000_0001},
        {1'b0, 64'hFFFF_FFFF_FFFF_FFFF},
        {1'b1, 64'h8000_0000_0000_000A},
        {1'b0, 64'hA5A5_5A5A_0F0F_F0F3},
        {1'b1, 64'h1000_0000_0000_0008},
        {1'b0, 64'hDEAD_BEEF_CAFE_F00D}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_offchip = 1'b1;
    logic        cfg_fast = 1'b1;
    logic        cfg_inhibit_ovf = 1'b0;
    logic        probe_absent = 1'b0;
    logic        push_req = 1'b0;
    logic [4:0]  fifo_free = 5'd10;
    logic        fifo_pop, push_ok, core_stall, ovf_pulse, tr_clk;
    logic [3:0]  tr_data;
    logic        fifo_empty;
    logic [63:0] fifo_word;

    logic [63:0] q [64];
    logic [5:0]  head = '0;
    logic [5:0]  tail = '0;

    int checks = 0;
    int failures = 0;

    // receiver model state
    logic        prev_clk = 1'b0;
    logic        rx_busy = 1'b0;
    int          rx_cnt = 0;
    logic [63:0] rx_word = '0;
    int          rx_n = 0;
    int          toggles = 0;
    int          cyc_since = 0;
    int          last_iv = 0;
    logic [63:0] rx_q [64];
    int          st_tog [64];
    int          en_tog [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign fifo_empty = (head == tail);
    assign fifo_word  = q[head];

    always @(posedge clk) begin
        if (fifo_pop) head <= head + 1'b1;
    end

    always @(negedge clk) begin
        cyc_since = cyc_since + 1;
        if (tr_clk != prev_clk) begin
            toggles   = toggles + 1;
            last_iv   = cyc_since;
            cyc_since = 0;
            if (!rx_busy) begin
                if (tr_data != 4'd0) begin
                    rx_busy = 1'b1;
                    rx_word = {60'd0, tr_data};
                    rx_cnt  = 1;
                    st_tog[rx_n] = toggles;
                end
            end else begin
                rx_word = rx_word | ({60'd0, tr_data} << (4 * rx_cnt));
                rx_cnt  = rx_cnt + 1;
                if (rx_cnt == 16) begin
                    rx_busy = 1'b0;
                    rx_q[rx_n]   = rx_word;
                    en_tog[rx_n] = toggles;
                    rx_n = rx_n + 1;
                end
            end
        end
        prev_clk = tr_clk;
    end

    nibble_trace_tx dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_offchip     (cfg_offchip),
        .cfg_fast        (cfg_fast),
        .cfg_inhibit_ovf (cfg_inhibit_ovf),
        .probe_absent    (probe_absent),
        .fifo_empty      (fifo_empty),
        .fifo_word       (fifo_word),
        .fifo_pop        (fifo_pop),
        .push_req        (push_req),
        .fifo_free       (fifo_free),
        .push_ok         (push_ok),
        .core_stall      (core_stall),
        .ovf_pulse       (ovf_pulse),
        .tr_clk          (tr_clk),
        .tr_data         (tr_data)
    );

    task automatic check(input logic ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic push_word(input logic [63:0] w);
        q[tail] = w;
        tail = tail + 1'b1;
    endtask

    task automatic wait_rx(input int target);
        for (int i = 0; i < 400 && rx_n < target; i++) settle();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        checks++;
        $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int base;
        // R11: reset with a word already queued
        push_word(64'h1111_2222_3333_4447);
        repeat (4) settle();
        check(tr_data == 4'd0 && !tr_clk && !fifo_pop, "R11 reset quiet",
              {59'd0, fifo_pop, tr_clk, tr_data}, 64'd0);
        check(head == 6'd0, "R11 no pop in reset", {58'd0, head}, 64'd0);
        rst_n = 1'b1;
        wait_rx(1);
        check(rx_n == 1 && rx_q[0] == 64'h1111_2222_3333_4447, "R1 word after reset",
              rx_q[0], 64'h1111_2222_3333_4447);

        // vector table: one word per entry, R1 with R3/R4 rate checks
        for (int i = 0; i < NVEC; i++) begin
            base = rx_n;
            settle();
            cfg_fast = VEC[i][64];
            repeat (4) settle();
            push_word(VEC[i][63:0]);
            wait_rx(base + 1);
            check(rx_q[base] == VEC[i][63:0], "R1 nibble order",
                  rx_q[base], VEC[i][63:0]);
            if (VEC[i][64])
                check(last_iv == 1, "R3 fast nibble rate", 64'(last_iv), 64'd1);
            else
                check(last_iv == 2, "R4 slow nibble rate", 64'(last_iv), 64'd2);
        end

        // R2: idle port is zero while the clock runs
        cfg_fast = 1'b1;
        begin
            int t0;
            logic nz;
            t0 = toggles;
            nz = 1'b0;
            for (int i = 0; i < 20; i++) begin
                settle();
                if (tr_data != 4'd0) nz = 1'b1;
            end
            check(!nz, "R2 idle data zero", {63'd0, nz}, 64'd0);
            check(toggles - t0 >= 18, "R2 clock runs in idle", 64'(toggles - t0), 64'd20);
        end

        // R6 / R7: burst of three words, fast
        base = rx_n;
        push_word(64'h0000_0000_0000_00A1);
        push_word(64'h1234_0000_0000_00B2);
        push_word(64'hFFFF_0000_0000_00C3);
        for (int i = 0; i < 100 && !(rx_busy && rx_cnt == 8); i++) settle();
        check(tail - head == 6'd2, "R6 one pop per word", 64'(tail - head), 64'd2);
        wait_rx(base + 3);
        check(rx_q[base + 2] == 64'hFFFF_0000_0000_00C3, "R1 burst word",
              rx_q[base + 2], 64'hFFFF_0000_0000_00C3);
        check(st_tog[base + 1] == en_tog[base] + 1, "R7 fast back to back",
              64'(st_tog[base + 1]), 64'(en_tog[base] + 1));
        check(st_tog[base + 2] == en_tog[base + 1] + 1, "R7 fast back to back 2",
              64'(st_tog[base + 2]), 64'(en_tog[base + 1] + 1));

        // R7: burst of two words, slow
        cfg_fast = 1'b0;
        base = rx_n;
        push_word(64'h5555_0000_0000_0005);
        push_word(64'h6666_0000_0000_0006);
        wait_rx(base + 2);
        check(st_tog[base + 1] == en_tog[base] + 1, "R7 slow back to back",
              64'(st_tog[base + 1]), 64'(en_tog[base] + 1));

        // R5: probe absent disables the port
        begin
            int t0;
            logic [5:0] h0;
            settle();
            probe_absent = 1'b1;
            repeat (3) settle();
            t0 = toggles;
            h0 = head;
            push_word(64'h0000_0000_0000_0009);
            repeat (40) settle();
            check(toggles == t0 && !tr_clk && tr_data == 4'd0, "R5 probe absent quiet",
                  64'(toggles - t0), 64'd0);
            check(head == h0, "R5 probe absent no pop", {58'd0, head}, {58'd0, h0});
            // off-chip disabled with probe present
            probe_absent = 1'b0;
            cfg_offchip  = 1'b0;
            cfg_fast     = 1'b1;
            repeat (40) settle();
            check(toggles == t0 && head == h0, "R5 offchip off quiet",
                  64'(toggles - t0), 64'd0);
            base = rx_n;
            cfg_offchip = 1'b1;
            wait_rx(base + 1);
            check(rx_q[base] == 64'h0000_0000_0000_0009, "R5 resumes on enable",
                  rx_q[base], 64'h9);
        end

        // R8 / R9 / R10: write-side guard
        settle();
        cfg_offchip = 1'b1; cfg_inhibit_ovf = 1'b1; push_req = 1'b1; fifo_free = 5'd3;
        #1;
        check(core_stall && push_ok && !ovf_pulse, "R8 stall at threshold",
              {61'd0, core_stall, push_ok, ovf_pulse}, 64'b110);
        fifo_free = 5'd4; #1;
        check(!core_stall, "R8 no stall above threshold", {63'd0, core_stall}, 64'd0);
        fifo_free = 5'd0; #1;
        check(core_stall && !push_ok && !ovf_pulse, "R10 full not accepted",
              {61'd0, core_stall, push_ok, ovf_pulse}, 64'b100);
        cfg_inhibit_ovf = 1'b0; #1;
        check(ovf_pulse && !push_ok && !core_stall, "R9 drop flagged",
              {61'd0, core_stall, push_ok, ovf_pulse}, 64'b001);
        push_req = 1'b0; #1;
        check(!ovf_pulse, "R9 no drop without request", {63'd0, ovf_pulse}, 64'd0);
        push_req = 1'b1; cfg_offchip = 1'b0; cfg_inhibit_ovf = 1'b1; #1;
        check(!core_stall && !ovf_pulse, "R8 inhibit ignored on-chip",
              {62'd0, core_stall, ovf_pulse}, 64'd0);
        fifo_free = 5'd2; #1;
        check(push_ok && !core_stall, "R10 accept with space",
              {62'd0, push_ok, core_stall}, 64'b10);
        push_req = 1'b0;
        settle();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule